// File: doc/BRIEF.md
# Retransmitting Packet Sender

This block sends one message at a time from a local client over a byte-wide link. The client first fills a word store with up to `MAX_WORDS` 32-bit words. It then issues a start request that carries a destination address and a word count. The block frames the message: a four-byte header goes first, then the payload, then a one-byte checksum trailer. The frame leaves one byte per accepted handshake on the link.

The message stays in the store after it has been sent. It is released only by a matching acknowledgment or by a final failure. A cycle timer begins with each transmission. If it reaches the timeout value before an acknowledgment arrives, the same frame is sent again from its first byte. When the retry budget is used up, a sticky failure flag is raised and the block returns to idle. The timeout period and the retry budget are run-time inputs.

Top module: `retx_packet_sender`

## Requirements
- R1: A frame consists of the following bytes, in this order: the network identifier (`NET_ID`), the destination address, the local address (`SRC_ID`), and the payload word count. The payload words follow, in index order from 0, and each word is sent most-significant byte first.
- R2: The last byte of every frame is the 8-bit wrapping sum of all bytes that come before it in that frame.
- R3: The frame advances only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` stays high and `tx_byte` holds its value.
- R4: A start request made while idle is accepted, and `busy` is high from the next cycle. A start request made while `busy` is high has no effect on the frame in progress.
- R5: Store writes made while `busy` is high are ignored. Every retransmission repeats the first frame byte for byte.
- R6: Once the last byte has been sent, an acknowledgment whose source equals the frame's destination completes the transfer. `busy` falls and `done` pulses for exactly one cycle. An acknowledgment with any other source is ignored. A matching acknowledgment wins over a timeout in the same cycle.
- R7: The timer counts cycles from the first cycle of each transmission. When it has reached `timeout_cycles` after the last byte has gone out, the frame restarts from its first byte and the timer restarts from zero.
- R8: A timeout after `max_retries` retransmissions sets `fail` and releases the block to idle. `fail` then stays high until the next start request is accepted.
- R9: After reset, `busy`, `tx_valid`, `done` and `fail` are low.
- R10: An acknowledgment that arrives while the frame is still being sent is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one word into the message store (idle only) |
| load_idx | input | AW | Word index to write |
| load_word | input | 32 | Word value |
| start | input | 1 | Request to send the stored message |
| start_dest | input | 8 | Destination address of the request |
| start_len | input | LW | Payload length in words |
| timeout_cycles | input | TW | Acknowledgment wait limit in cycles |
| max_retries | input | RW | Number of retransmissions allowed |
| tx_valid | output | 1 | Link byte available |
| tx_byte | output | 8 | Link byte |
| tx_ready | input | 1 | Link accepts the byte |
| ack_valid | input | 1 | Acknowledgment received |
| ack_src | input | 8 | Source address of the acknowledgment |
| busy | output | 1 | A message is outstanding |
| done | output | 1 | One-cycle pulse on successful completion |
| fail | output | 1 | Sticky retry-exhausted flag |

## Verification
The hardest state to reach is the cycle in which the timer expiry and a matching acknowledgment coincide on the last permitted attempt. The retry budget is zero in that case, so any loss of the acknowledgment turns straight into a failure. The bench reaches this cycle by tracking its reference timer and raising the acknowledgment exactly when the model shows the limit reached. Retransmission under link back-pressure is driven with a pseudo-random ready pattern and a timeout shorter than a stalled frame, so expiries land just after the last byte. Writes and start requests issued mid-transfer confirm that the replayed frames stay identical.

// File: rtl/retx_sender_pkg.sv
package retx_sender_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} snd_state_e;

  localparam int HDR_BYTES = 4;

  // big-endian lane pick: lane 0 is bits 31:24
  function automatic logic [7:0] word_lane(input logic [31:0] w, input logic [1:0] lane);
    return w[8*(3-lane) +: 8];
  endfunction
endpackage

// File: rtl/pkt_word_store.sv
module pkt_word_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pkt_byte_sel.sv
module pkt_byte_sel
  import retx_sender_pkg::*;
#(
  parameter int           IW     = 6,
  parameter int           LW     = 4,
  parameter int           AW     = 3,
  parameter logic [7:0]   NET_ID = 8'hA5,
  parameter logic [7:0]   SRC_ID = 8'h3C
) (
  input  logic [IW-1:0] idx,
  input  logic [LW-1:0] len,
  input  logic [7:0]    dest,
  input  logic [7:0]    sum,
  input  logic [31:0]   word,
  output logic [AW-1:0] word_addr,
  output logic          is_last,
  output logic [7:0]    byte_out
);
  logic [IW-1:0] last_idx;

  assign last_idx  = IW'(HDR_BYTES) + (IW'(len) << 2);
  assign is_last   = (idx == last_idx);
  assign word_addr = AW'((idx >> 2) - IW'(1));

  always_comb begin
    if (is_last) byte_out = sum;
    else begin
      case (idx)
        IW'(0):  byte_out = NET_ID;
        IW'(1):  byte_out = dest;
        IW'(2):  byte_out = SRC_ID;
        IW'(3):  byte_out = 8'(len);
        default: byte_out = word_lane(word, idx[1:0]);
      endcase
    end
  end
endmodule

// File: rtl/retry_timer.sv
module retry_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)             cnt <= '0;
    else if (run && cnt != '1)    cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);
endmodule

// File: rtl/retx_packet_sender.sv
module retx_packet_sender
  import retx_sender_pkg::*;
#(
  parameter int         MAX_WORDS = 8,
  parameter int         TW        = 16,
  parameter int         RW        = 4,
  parameter logic [7:0] NET_ID    = 8'hA5,
  parameter logic [7:0] SRC_ID    = 8'h3C,
  localparam int        AW        = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int        LW        = $clog2(MAX_WORDS + 1),
  localparam int        IW        = $clog2(HDR_BYTES + 4*MAX_WORDS + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [AW-1:0] load_idx,
  input  logic [31:0]   load_word,
  input  logic          start,
  input  logic [7:0]    start_dest,
  input  logic [LW-1:0] start_len,
  input  logic [TW-1:0] timeout_cycles,
  input  logic [RW-1:0] max_retries,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  input  logic          tx_ready,
  input  logic          ack_valid,
  input  logic [7:0]    ack_src,
  output logic          busy,
  output logic          done,
  output logic          fail
);
  snd_state_e    state;
  logic [IW-1:0] idx;
  logic [LW-1:0] len_q;
  logic [7:0]    dest_q;
  logic [7:0]    sum_q;
  logic [RW-1:0] tries_q;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_word;
  logic          is_last;
  logic          expired;
  logic          ack_hit;
  logic          accept;
  logic          replay_or_quit;

  assign accept         = (state == ST_IDLE) && start;
  assign ack_hit        = (state == ST_WAIT) && ack_valid && (ack_src == dest_q);
  assign replay_or_quit = (state == ST_WAIT) && !ack_hit && expired;

  pkt_word_store #(.DEPTH(MAX_WORDS), .AW(AW)) u_store (
    .clk   (clk),
    .we    (load_en && state == ST_IDLE),
    .waddr (load_idx),
    .wdata (load_word),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  pkt_byte_sel #(.IW(IW), .LW(LW), .AW(AW), .NET_ID(NET_ID), .SRC_ID(SRC_ID)) u_sel (
    .idx       (idx),
    .len       (len_q),
    .dest      (dest_q),
    .sum       (sum_q),
    .word      (rd_word),
    .word_addr (rd_addr),
    .is_last   (is_last),
    .byte_out  (tx_byte)
  );

  retry_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept || replay_or_quit),
    .run     (state != ST_IDLE),
    .limit   (timeout_cycles),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx     <= '0;
      len_q   <= '0;
      dest_q  <= '0;
      sum_q   <= '0;
      tries_q <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          dest_q  <= start_dest;
          len_q   <= start_len;
          idx     <= '0;
          sum_q   <= '0;
          tries_q <= '0;
          fail    <= 1'b0;
          state   <= ST_SEND;
        end
        ST_SEND: if (tx_ready) begin
          sum_q <= sum_q + tx_byte;
          if (is_last) state <= ST_WAIT;
          else         idx   <= idx + 1'b1;
        end
        ST_WAIT: begin
          if (ack_hit) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (expired) begin
            if (tries_q == max_retries) begin
              fail  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              tries_q <= tries_q + 1'b1;
              idx     <= '0;
              sum_q   <= '0;
              state   <= ST_SEND;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_valid = (state == ST_SEND);
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/retx_packet_sender_chk.sv
module retx_packet_sender_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte,
  input logic       busy,
  input logic       done,
  input logic       fail
);
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

  assert_accept_R4: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy && tx_valid);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !fail);

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    fail && !start |=> fail);

  assert_fail_release_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> !busy && !done);
endmodule

bind retx_packet_sender retx_packet_sender_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_byte  (tx_byte),
  .busy     (busy),
  .done     (done),
  .fail     (fail)
);

// File: tb/retx_packet_sender_test.sv
module retx_packet_sender_test;
  localparam int         MAXW = 8;
  localparam int         TW   = 16;
  localparam int         RW   = 4;
  localparam logic [7:0] NET  = 8'hA5;
  localparam logic [7:0] SRC  = 8'h3C;
  localparam int         AW   = 3;
  localparam int         LW   = 4;

  typedef logic [7:0] bq_t[$];

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b0;
  logic [AW-1:0] load_idx = '0;
  logic [31:0]   load_word = '0;
  logic          start = 1'b0;
  logic [7:0]    start_dest = '0;
  logic [LW-1:0] start_len = '0;
  logic [TW-1:0] timeout_cycles = 16'd200;
  logic [RW-1:0] max_retries = 4'd2;
  logic          tx_valid;
  logic [7:0]    tx_byte;
  logic          tx_ready = 1'b1;
  logic          ack_valid = 1'b0;
  logic [7:0]    ack_src = '0;
  logic          busy, done, fail;

  always #2 clk = ~clk;

  retx_packet_sender #(.MAX_WORDS(MAXW), .TW(TW), .RW(RW), .NET_ID(NET), .SRC_ID(SRC)) uut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_idx(load_idx), .load_word(load_word),
    .start(start), .start_dest(start_dest), .start_len(start_len),
    .timeout_cycles(timeout_cycles), .max_retries(max_retries),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .ack_valid(ack_valid), .ack_src(ack_src), .busy(busy), .done(done), .fail(fail)
  );

  int n_chk = 0;
  int n_err = 0;
  bit cmp_en = 1'b0;
  int rdy_mode = 0;
  bq_t cap;
  logic [31:0] w_ref [MAXW];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // frame per R1/R2
  function automatic bq_t mk(input logic [7:0] d, input int n, input logic [31:0] w [MAXW]);
    bq_t q;
    logic [7:0] s;
    q.push_back(NET); q.push_back(d); q.push_back(SRC); q.push_back(8'(n));
    for (int i = 0; i < n; i++)
      for (int b = 3; b >= 0; b--) q.push_back(w[i][8*b +: 8]);
    s = 8'h00;
    foreach (q[i]) s = s + q[i];
    q.push_back(s);
    return q;
  endfunction

  // behavioural reference model
  int          m_state = 0;
  int          m_pos = 0;
  int          m_timer = 0;
  int          m_retry = 0;
  bit          m_done = 0;
  bit          m_fail = 0;
  logic [7:0]  m_dest = '0;
  logic [31:0] m_mem [MAXW];
  bq_t         m_pkt;

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_done = 0; m_fail = 0;
    end else begin
      m_done = 0;
      case (m_state)
        0: begin
          if (load_en) m_mem[load_idx] = load_word;
          if (start) begin
            m_dest = start_dest;
            m_pkt = mk(start_dest, int'(start_len), m_mem);
            m_pos = 0; m_timer = 0; m_retry = 0; m_fail = 0; m_state = 1;
          end
        end
        1: begin
          if (m_timer < 65535) m_timer++;
          if (tx_ready) begin
            if (m_pos == m_pkt.size() - 1) m_state = 2;
            else m_pos++;
          end
        end
        default: begin
          if (ack_valid && ack_src == m_dest) begin
            m_state = 0; m_done = 1;
          end else if (m_timer >= int'(timeout_cycles)) begin
            if (m_retry == int'(max_retries)) begin
              m_fail = 1; m_state = 0;
            end else begin
              m_retry++; m_pos = 0; m_timer = 0; m_state = 1;
            end
          end else if (m_timer < 65535) m_timer++;
        end
      endcase
    end
  end

  // compare, capture and link-ready generation, all at the falling edge
  always @(negedge clk) begin
    bit pv;
    logic [7:0] pb;
    if (cmp_en) begin
      chk(busy == (m_state != 0), "R4", "busy vs model", busy, m_state != 0);
      chk(tx_valid == (m_state == 1), "R3", "tx_valid vs model", tx_valid, m_state == 1);
      if (m_state == 1)
        chk(tx_byte == m_pkt[m_pos], "R1", "tx_byte vs model", tx_byte, m_pkt[m_pos]);
      chk(done == m_done, "R6", "done vs model", done, m_done);
      chk(fail == m_fail, "R8", "fail vs model", fail, m_fail);
    end
    pv = tx_valid;
    pb = tx_byte;
    tx_ready = (rdy_mode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
    if (pv && tx_ready && cmp_en) cap.push_back(pb);
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic load_w(input int i, input logic [31:0] w, input bit idle);
    load_en = 1'b1; load_idx = AW'(i); load_word = w;
    if (idle) w_ref[i] = w;
    tick();
    load_en = 1'b0;
  endtask

  task automatic go(input logic [7:0] d, input int n);
    start = 1'b1; start_dest = d; start_len = LW'(n);
    tick();
    start = 1'b0;
  endtask

  task automatic ack_pulse(input logic [7:0] s);
    ack_valid = 1'b1; ack_src = s;
    tick();
    ack_valid = 1'b0;
  endtask

  task automatic wait_state(input int s);
    while (m_state != s) tick();
  endtask

  task automatic cmp_frame(input bq_t exp, input int copies, input string req);
    bit ok;
    int bad;
    ok = (cap.size() == exp.size() * copies);
    chk(ok, req, "frame byte count", cap.size(), exp.size() * copies);
    bad = -1;
    if (ok)
      for (int i = 0; i < cap.size(); i++)
        if (bad < 0 && cap[i] != exp[i % exp.size()]) bad = i;
    if (ok)
      chk(bad < 0, req, "frame content", (bad < 0) ? 0 : cap[bad],
          (bad < 0) ? 0 : exp[bad % exp.size()]);
  endtask

  initial begin
    bq_t e;
    logic [7:0] s;
    for (int i = 0; i < MAXW; i++) begin m_mem[i] = '0; w_ref[i] = '0; end
    repeat (4) tick();
    rst = 1'b0;
    chk(!busy, "R9", "busy after reset", busy, 0);
    chk(!tx_valid, "R9", "tx_valid after reset", tx_valid, 0);
    chk(!done, "R9", "done after reset", done, 0);
    chk(!fail, "R9", "fail after reset", fail, 0);
    cmp_en = 1'b1;

    for (int i = 0; i < MAXW; i++) load_w(i, 32'h1122_3344 * (i + 1) + 32'h0F0F_00A0, 1'b1);

    // T1: clean send, refused start and write mid-flight, wrong then right ack
    cap.delete();
    go(8'h22, 3);
    go(8'h77, 5);                      // R4 ignored while busy
    load_w(0, 32'hDEAD_BEEF, 1'b0);    // R5 ignored while busy
    wait_state(2);
    ack_pulse(8'h23);
    chk(busy, "R6", "busy after wrong ack", busy, 1);
    ack_pulse(8'h22);
    chk(done, "R6", "done after matching ack", done, 1);
    tick();
    chk(!done && !busy, "R6", "done single pulse / idle", {done, busy}, 0);
    e = mk(8'h22, 3, w_ref);
    cmp_frame(e, 1, "R1");
    s = 8'h00;
    for (int i = 0; i < cap.size() - 1; i++) s = s + cap[i];
    chk(cap.size() > 0 && cap[cap.size()-1] == s, "R2", "checksum trailer",
        cap.size() > 0 ? cap[cap.size()-1] : 0, s);

    // T2: no ack, back-pressure, retries exhausted
    rdy_mode = 1; timeout_cycles = 16'd30; max_retries = 4'd2;
    cap.delete();
    go(8'h44, 3);
    load_w(1, 32'h0BAD_F00D, 1'b0);
    wait_state(0);
    e = mk(8'h44, 3, w_ref);
    cmp_frame(e, 3, "R5");
    chk(cap.size() == 3 * e.size(), "R7", "three transmissions", cap.size(), 3 * e.size());
    chk(fail && !busy, "R8", "fail set and released", {fail, busy}, 2'b10);

    // T3: sticky fail, clear on start, ack during send, ack on expiry cycle
    repeat (5) tick();
    chk(fail, "R8", "fail sticky while idle", fail, 1);
    rdy_mode = 0; timeout_cycles = 16'd20; max_retries = 4'd0;
    go(8'h55, 1);
    chk(!fail, "R8", "fail cleared by start", fail, 0);
    ack_pulse(8'h55);
    chk(busy && !done, "R10", "ack during send ignored", {busy, done}, 2'b10);
    while (!(m_state == 2 && m_timer >= 20)) tick();
    ack_pulse(8'h55);
    chk(done && !fail, "R6", "ack wins over expiry", {done, fail}, 2'b10);

    // T4: empty and full-length messages
    timeout_cycles = 16'd200; max_retries = 4'd1;
    cap.delete();
    go(8'h66, 0);
    wait_state(2);
    ack_pulse(8'h66);
    cmp_frame(mk(8'h66, 0, w_ref), 1, "R1");
    rdy_mode = 1;
    cap.delete();
    go(8'h67, MAXW);
    wait_state(2);
    ack_pulse(8'h67);
    e = mk(8'h67, MAXW, w_ref);
    cmp_frame(e, 1, "R2");
    tick();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule